// File: doc/BRIEF.md
# Integer multi-operation ALU

This block is a 64-bit integer execution unit. Each beat carries a 6-bit operation code, an operand-width select and up to three source operands. The block computes one of a fixed set of integer operations and presents the result from an output register one cycle after the beat is accepted. The operations are add, subtract and reverse subtract; signed and unsigned minimum and maximum; AND, OR and XOR; left shift and the two kinds of right shift; rotate; clear, set, toggle and test of a single bit; two bit-group tests; a three-input bitwise select; and a funnel shift. A code that names no implemented operation does not produce a result. It raises a trap flag instead.

Both the input and the output are valid/ready streams. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the unit holds at most one result. If the consumer holds `out_ready` low, the result, the trap flag and `out_valid` stay frozen, and `in_ready` stays low until the result is taken. No beat is lost or duplicated.

Top module: `alu_exec_unit`

## Requirements
- R1: A beat accepted on a clock edge appears on `out_valid`/`out_result`/`out_trap` after that edge. While `out_valid` is high and `out_ready` is low, all three outputs hold their values and `in_ready` is low. `in_ready` is high whenever `out_valid` is low.
- R2: `in_size` selects the operand width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Sources are truncated to that width. Every result is truncated to that width and zero-extended to 64 bits.
- R3: Code 8 gives src1+src2, code 9 gives src1-src2 and code 10 gives src2-src1, each wrapping at the selected width.
- R4: Codes 20 and 22 give the signed minimum and maximum of src1 and src2 at the selected width. Codes 21 and 23 give the unsigned minimum and maximum.
- R5: Codes 26, 27 and 28 give src1 AND, OR and XOR src2. Code 52 gives (src1 & src3) | (src2 & ~src3).
- R6: Code 32 shifts src1 left, code 34 shifts it right with sign extension and code 35 shifts it right with zero fill. The shift count is src2 modulo the width.
- R7: Code 33 rotates src1 within the width. When src2, read as a signed number of that width, is zero or positive, it rotates left by src2 modulo the width. When src2 is negative, it rotates right by its magnitude modulo the width.
- R8: Codes 36, 37 and 38 clear, set and toggle bit (src2 modulo width) of src1. Code 39 returns that bit of src1 as 0 or 1.
- R9: Code 40 returns 1 when every bit set in src2 is also set in src1, else 0. Code 41 returns 1 when src1 and src2 share at least one set bit, else 0.
- R10: Code 53 forms a double-width value with src1 as the low half and src2 as the high half. It shifts that value right by (src3 modulo width) and returns the low width bits.
- R11: Code 0 is a no-operation. It completes with result 0 and no trap.
- R12: Code 63 and every code not listed in R3–R11 complete with `out_trap` high and leave `out_result` at its previous value. Implemented codes complete with `out_trap` low.
- R13: After reset, `out_valid`, `out_trap` and `out_result` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take an input beat |
| in_opcode | input | 6 | Operation code |
| in_size | input | 2 | Operand width select (8/16/32/64) |
| in_src1 | input | 64 | First source operand |
| in_src2 | input | 64 | Second source operand (also shift/bit count) |
| in_src3 | input | 64 | Third source operand (select mask, funnel count) |
| out_valid | output | 1 | Result register holds an unconsumed beat |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Zero-extended result |
| out_trap | output | 1 | The held beat carried an unimplemented code |

## Verification
The hardest cases to reach from the ports are a trap beat and a stalled output. A trap beat is only meaningful when the value it must preserve is known and non-trivial. The sweep therefore walks all 64 codes in order at every width, so each unused code follows a real result, and the bench tracks that last result independently. The stall case needs a second beat waiting while the output register is blocked. A directed sequence lowers `out_ready`, keeps a new beat on the input for several cycles, then releases it and checks that exactly that beat is taken on the release edge.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  localparam int unsigned OPC_W = 6;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP   = 6'd0,
    OPC_ADD   = 6'd8,
    OPC_SUB   = 6'd9,
    OPC_RSUB  = 6'd10,
    OPC_MIN   = 6'd20,
    OPC_MINU  = 6'd21,
    OPC_MAX   = 6'd22,
    OPC_MAXU  = 6'd23,
    OPC_AND   = 6'd26,
    OPC_OR    = 6'd27,
    OPC_XOR   = 6'd28,
    OPC_SHL   = 6'd32,
    OPC_ROT   = 6'd33,
    OPC_SHRS  = 6'd34,
    OPC_SHRU  = 6'd35,
    OPC_BCLR  = 6'd36,
    OPC_BSET  = 6'd37,
    OPC_BFLIP = 6'd38,
    OPC_BTEST = 6'd39,
    OPC_TALL  = 6'd40,
    OPC_TANY  = 6'd41,
    OPC_BSEL  = 6'd52,
    OPC_FUNNL = 6'd53,
    OPC_UNDEF = 6'd63
  } opc_e;

  function automatic logic opc_known(input logic [OPC_W-1:0] code);
    case (code)
      OPC_NOP, OPC_ADD, OPC_SUB, OPC_RSUB,
      OPC_MIN, OPC_MINU, OPC_MAX, OPC_MAXU,
      OPC_AND, OPC_OR, OPC_XOR,
      OPC_SHL, OPC_ROT, OPC_SHRS, OPC_SHRU,
      OPC_BCLR, OPC_BSET, OPC_BFLIP, OPC_BTEST,
      OPC_TALL, OPC_TANY, OPC_BSEL, OPC_FUNNL: return 1'b1;
      default:                                 return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  opc_e                     op,
  input  logic        [DATA_W-1:0] opa,
  input  logic        [DATA_W-1:0] opb,
  input  logic signed [DATA_W-1:0] sxa,
  input  logic signed [DATA_W-1:0] sxb,
  output logic        [DATA_W-1:0] res
);

  logic s_lt, u_lt;
  assign s_lt = sxa < sxb;
  assign u_lt = opa < opb;

  always_comb begin
    case (op)
      OPC_ADD:  res = opa + opb;
      OPC_SUB:  res = opa - opb;
      OPC_RSUB: res = opb - opa;
      OPC_MIN:  res = s_lt ? opa : opb;
      OPC_MAX:  res = s_lt ? opb : opa;
      OPC_MINU: res = u_lt ? opa : opb;
      OPC_MAXU: res = u_lt ? opb : opa;
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned AMT_W  = $clog2(DATA_W),
  parameter int unsigned CNT_W  = AMT_W + 1
) (
  input  opc_e                     op,
  input  logic        [DATA_W-1:0] opa,
  input  logic        [DATA_W-1:0] opb,
  input  logic signed [DATA_W-1:0] sxa,
  input  logic        [AMT_W-1:0]  amt,
  input  logic        [AMT_W-1:0]  famt,
  input  logic        [CNT_W-1:0]  lane_bits,
  output logic        [DATA_W-1:0] res
);

  localparam int unsigned PAIR_W = 2 * DATA_W;

  logic [CNT_W-1:0]  back_amt;
  logic [DATA_W-1:0] rot_val;
  logic [PAIR_W-1:0] pair;
  logic [PAIR_W-1:0] pair_sh;

  // Rotating left by the count modulo the width equals rotating right by
  // the magnitude of a negative count, since the width divides 2**width.
  assign back_amt = lane_bits - {1'b0, amt};
  assign rot_val  = (opa << amt) | (opa >> back_amt);

  assign pair    = ({{DATA_W{1'b0}}, opb} << lane_bits) | {{DATA_W{1'b0}}, opa};
  assign pair_sh = pair >> famt;

  always_comb begin
    case (op)
      OPC_SHL:   res = opa << amt;
      OPC_SHRS:  res = DATA_W'(sxa >>> amt);
      OPC_SHRU:  res = opa >> amt;
      OPC_ROT:   res = rot_val;
      OPC_FUNNL: res = pair_sh[DATA_W-1:0];
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  opc_e              op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] opc,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] res
);

  logic [DATA_W-1:0] one_hot;
  logic              common;

  assign one_hot = {{(DATA_W-1){1'b0}}, 1'b1} << amt;
  assign common  = |(opa & opb);

  always_comb begin
    case (op)
      OPC_AND:   res = opa & opb;
      OPC_OR:    res = opa | opb;
      OPC_XOR:   res = opa ^ opb;
      OPC_BCLR:  res = opa & ~one_hot;
      OPC_BSET:  res = opa | one_hot;
      OPC_BFLIP: res = opa ^ one_hot;
      OPC_BTEST: res = {{(DATA_W-1){1'b0}}, opa[amt]};
      OPC_TALL:  res = {{(DATA_W-1){1'b0}}, ((opa & opb) == opb)};
      OPC_TANY:  res = {{(DATA_W-1){1'b0}}, common};
      OPC_BSEL:  res = (opa & opc) | (opb & ~opc);
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/alu_exec_unit.sv
module alu_exec_unit
  import alu_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NUM_SZ = $clog2(DATA_W / 8) + 1,
  parameter int unsigned SZ_W   = $clog2(NUM_SZ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [SZ_W-1:0]   in_size,
  input  logic [DATA_W-1:0] in_src1,
  input  logic [DATA_W-1:0] in_src2,
  input  logic [DATA_W-1:0] in_src3,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_trap
);

  localparam int unsigned AMT_W = $clog2(DATA_W);
  localparam int unsigned CNT_W = AMT_W + 1;

  logic [DATA_W-1:0] mask_tab  [NUM_SZ];
  logic [CNT_W-1:0]  width_tab [NUM_SZ];

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_lane
    assign width_tab[g] = CNT_W'(8 << g);
    assign mask_tab[g]  = ~({DATA_W{1'b1}} << (8 << g));
  end

  logic [DATA_W-1:0]        lane_mask;
  logic [CNT_W-1:0]         lane_bits;
  logic [CNT_W-1:0]         ext_sh;
  logic [AMT_W-1:0]         amt_mask;
  logic [DATA_W-1:0]        opa, opb, opc;
  logic signed [DATA_W-1:0] sxa, sxb;
  logic [AMT_W-1:0]         amt, famt;
  opc_e                     op;

  assign lane_mask = mask_tab[in_size];
  assign lane_bits = width_tab[in_size];
  assign ext_sh    = CNT_W'(DATA_W) - lane_bits;
  assign amt_mask  = lane_bits[AMT_W-1:0] - AMT_W'(1);

  assign opa  = in_src1 & lane_mask;
  assign opb  = in_src2 & lane_mask;
  assign opc  = in_src3 & lane_mask;
  assign sxa  = $signed(opa << ext_sh) >>> ext_sh;
  assign sxb  = $signed(opb << ext_sh) >>> ext_sh;
  assign amt  = in_src2[AMT_W-1:0] & amt_mask;
  assign famt = in_src3[AMT_W-1:0] & amt_mask;
  assign op   = opc_e'(in_opcode);

  logic [DATA_W-1:0] res_arith, res_shift, res_bits, res_lane;

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op  (op),
    .opa (opa),
    .opb (opb),
    .sxa (sxa),
    .sxb (sxb),
    .res (res_arith)
  );

  alu_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W), .CNT_W(CNT_W)) u_shift (
    .op        (op),
    .opa       (opa),
    .opb       (opb),
    .sxa       (sxa),
    .amt       (amt),
    .famt      (famt),
    .lane_bits (lane_bits),
    .res       (res_shift)
  );

  alu_bitops #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_bits (
    .op  (op),
    .opa (opa),
    .opb (opb),
    .opc (opc),
    .amt (amt),
    .res (res_bits)
  );

  // Each unit returns zero for codes outside its group.
  assign res_lane = (res_arith | res_shift | res_bits) & lane_mask;

  logic take, known;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign known    = opc_known(in_opcode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_trap   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_trap  <= !known;
      if (known) out_result <= res_lane;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/alu_exec_unit_chk.sv
module alu_exec_unit_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned SZ_W   = $clog2($clog2(DATA_W / 8) + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [5:0]        in_opcode,
  input logic [SZ_W-1:0]   in_size,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_trap
);

  a_r1_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r1_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_trap));

  a_r1_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r2_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_size == '0 |=> out_trap || (out_result >> 8) == '0);

  a_r9_test_boolean: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_opcode == 6'd39 || in_opcode == 6'd40 || in_opcode == 6'd41)
    |=> !out_trap && out_result <= DATA_W'(1));

  a_r11_nop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode == 6'd0 |=> !out_trap && out_result == '0);

  a_r12_trap_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_opcode == 6'd63 |=> out_trap && $stable(out_result));

endmodule

bind alu_exec_unit alu_exec_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_opcode  (in_opcode),
  .in_size    (in_size),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_trap   (out_trap)
);

// File: tb/test_alu_exec_unit.sv
`timescale 1ns/1ps
module test_alu_exec_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_opcode = '0;
  logic [1:0]  in_size = '0;
  logic [63:0] in_src1 = '0, in_src2 = '0, in_src3 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_trap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] last_res = '0;

  always #2 clk = ~clk;

  alu_exec_unit i_alu_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_size(in_size), .in_src1(in_src1),
    .in_src2(in_src2), .in_src3(in_src3), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_trap(out_trap)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0:              return "R11";
      8, 9, 10:       return "R3";
      20, 21, 22, 23: return "R4";
      26, 27, 28, 52: return "R5";
      32, 34, 35:     return "R6";
      33:             return "R7";
      36, 37, 38, 39: return "R8";
      40, 41:         return "R9";
      53:             return "R10";
      default:        return "R12";
    endcase
  endfunction

  // Reference model, bitwise where practical.
  task automatic model(input int op, input int sz, input logic [63:0] a_in,
                       input logic [63:0] b_in, input logic [63:0] c_in,
                       output logic [63:0] r, output logic trap);
    int n;
    logic [63:0] m, a, b, c, sb;
    int k;
    n  = 8 << sz;
    m  = (n == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << n) - 64'd1);
    a  = a_in & m; b = b_in & m; c = c_in & m;
    sb = 64'd1 << (n - 1);
    k  = int'(b % 64'(n));
    r  = '0;
    trap = 1'b0;
    case (op)
      0:  r = '0;
      8:  r = a + b;
      9:  r = a - b;
      10: r = b - a;
      20: r = ((a ^ sb) < (b ^ sb)) ? a : b;
      22: r = ((a ^ sb) > (b ^ sb)) ? a : b;
      21: r = (a < b) ? a : b;
      23: r = (a > b) ? a : b;
      26: r = a & b;
      27: r = a | b;
      28: r = a ^ b;
      52: r = (a & c) | (b & ~c);
      32: for (int i = 0; i < n; i++) r[i] = (i >= k) ? a[i-k] : 1'b0;
      34: for (int i = 0; i < n; i++) r[i] = (i + k < n) ? a[i+k] : a[n-1];
      35: for (int i = 0; i < n; i++) r[i] = (i + k < n) ? a[i+k] : 1'b0;
      33: begin
        if ((b & sb) != 0) begin
          int kr;
          kr = int'(((~b + 64'd1) & m) % 64'(n));
          for (int i = 0; i < n; i++) r[i] = a[(i + kr) % n];
        end else begin
          for (int i = 0; i < n; i++) r[(i + k) % n] = a[i];
        end
      end
      36: begin r = a; r[k] = 1'b0; end
      37: begin r = a; r[k] = 1'b1; end
      38: begin r = a; r[k] = ~a[k]; end
      39: r = {63'd0, a[k]};
      40: r = ((a & b) == b) ? 64'd1 : 64'd0;
      41: r = ((a & b) != 0) ? 64'd1 : 64'd0;
      53: begin
        int kf;
        kf = int'(c % 64'(n));
        for (int i = 0; i < n; i++) r[i] = (i + kf < n) ? a[i+kf] : b[i+kf-n];
      end
      default: trap = 1'b1;
    endcase
    r = r & m;
  endtask

  task automatic pattern(input int p, output logic [63:0] a, output logic [63:0] b,
                         output logic [63:0] c);
    case (p)
      0: begin a = 64'h0123_4567_89AB_CDEF; b = 64'h5;                  c = 64'hF0F0_F0F0_F0F0_F0F0; end
      1: begin a = 64'h8000_0000_0000_0081; b = 64'hFFFF_FFFF_FFFF_FFFD; c = 64'h13; end
      2: begin a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'd70;                 c = 64'd3; end
      3: begin a = 64'h0000_00F0_0000_00F0; b = 64'h0000_0030_0000_0030; c = 64'h0F0F_0F0F_0F0F_0F0F; end
      4: begin a = 64'h7FFF_FFFF_7FFF_7F7F; b = 64'h8000_0000_8000_8080; c = 64'hAAAA_AAAA_AAAA_AAAA; end
      default: begin a = 64'h5; b = 64'h5; c = 64'd0; end
    endcase
  endtask

  // Present one beat, let the next edge take it, then compare.
  task automatic run_beat(input int op, input int sz, input logic [63:0] a,
                          input logic [63:0] b, input logic [63:0] c, input string tag);
    logic [63:0] er;
    logic        et;
    model(op, sz, a, b, c, er, et);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = 6'(op); in_size = 2'(sz);
    in_src1 = a; in_src2 = b; in_src3 = c;
    @(negedge clk);
    in_valid = 1'b0;
    if (et) er = last_res;
    else    last_res = er;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check({tag, " trap"},  {63'd0, out_trap},  {63'd0, et});
    check({tag, " result"}, out_result, er);
  endtask

  initial begin
    logic [63:0] pa, pb, pc;
    repeat (3) @(negedge clk);
    // R13: reset state
    check("R13 valid", {63'd0, out_valid}, 64'd0);
    check("R13 trap", {63'd0, out_trap}, 64'd0);
    check("R13 result", out_result, 64'd0);
    check("R13 ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: width select truncates and zero-extends
    run_beat(8, 0, 64'hFF, 64'h1, 64'h0, "R2 add8 wrap");
    run_beat(8, 1, 64'hFF, 64'h1, 64'h0, "R2 add16 carry");
    run_beat(9, 2, 64'h1_0000_0000, 64'h1, 64'h0, "R2 sub32 high ignored");

    // Sweep of every code, width and operand pattern
    for (int sz = 0; sz < 4; sz++)
      for (int p = 0; p < 6; p++) begin
        pattern(p, pa, pb, pc);
        for (int op = 0; op < 64; op++)
          run_beat(op, sz, pa, pb, pc, req_of(op));
      end

    // R1: back-pressure holds the result and blocks the input
    @(negedge clk);
    out_ready = 1'b0;
    run_beat(8, 3, 64'd1, 64'd2, 64'd0, "R1 stalled beat");
    in_valid = 1'b1; in_opcode = 6'd9; in_size = 2'd3;
    in_src1 = 64'd10; in_src2 = 64'd4; in_src3 = 64'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 ready low while stalled", {63'd0, in_ready}, 64'd0);
      check("R1 result held", out_result, 64'd3);
      check("R1 valid held", {63'd0, out_valid}, 64'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 waiting beat taken", out_result, 64'd6);
    check("R1 waiting beat valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    check("R1 drained", {63'd0, out_valid}, 64'd0);
    check("R1 ready when empty", {63'd0, in_ready}, 64'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule